// File: doc/BRIEF.md
# Global shutter exposure controller

This block drives the two active-low pixel strobes of a global-shutter image sensor. The "open" strobe empties every photodiode at once and starts integration. The "store" strobe copies the integrated charge into the analog memory that sits beside each pixel. The time between the falling edges of the two strobes is the exposure, set as a cycle count.

A start command runs one of three modes. Overlapped mode exposes the next frame while the readout sequencer is still reading the previous one. In this mode the store strobe lines up with the completion of the last row of the window, and the open strobe is placed the exposure length earlier. To do this the block counts down from each row-done indication using the row period and the last-row index. Expose-then-read mode waits for the readout to finish before it starts the next exposure. Single-shot mode captures one frame and then idles.

A memory-clear command pulses both strobes together. A frame-captured flag marks each store strobe.

Top module: `gshut_expo_ctrl`

## Requirements
- R1: While reset is applied and directly after it, both strobes are high, the frame flag is low and the block is idle.
- R2: `mode_i` is sampled with `start_i` while idle: 2'b00 overlapped, 2'b01 expose-then-read, 2'b10 single-shot, 2'b11 reserved. A start with 2'b11 does nothing. In the other modes the first open strobe goes low two cycles after the start cycle.
- R3: Each strobe pulse is low for exactly PULSE_W consecutive cycles.
- R4: The store strobe goes low exactly E cycles after the open strobe goes low. E is `expo_i` as sampled in the cycle the open pulse is decided.
- R5: An exposure request below PULSE_W, including zero, is raised to PULSE_W.
- R6: `frame_cap_o` is high for one cycle, in the first low cycle of each store pulse, and never for a memory clear.
- R7: A `clr_mem_i` pulse while idle, with no start in the same cycle, drives both strobes low in the cycle that follows, for PULSE_W cycles.
- R8: In overlapped mode, every frame after the first ends with the store strobe going low one cycle after the row-done of row `last_row_i`. The remaining time is taken as (last_row_i - row_idx_i) * row_len_i at each row-done.
- R9: In overlapped mode, when the exposure exceeds the remaining readout time at the first row-done of a readout, the open strobe goes low two cycles after that row-done. The store strobe then waits until the full exposure has run.
- R10: In expose-then-read mode, after each store strobe the block waits for the row-done of row `last_row_i`. Row-dones of other rows are ignored. The next open strobe goes low two cycles after that row-done.
- R11: Single-shot mode produces exactly one open and one store pulse and then returns to idle with no stop command.
- R12: `stop_i` while running lets the frame in progress finish and then returns to idle. No further strobe follows.
- R13: The two strobes are never low in the same cycle unless both went low in the same cycle for a memory clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, taken while idle |
| stop_i | input | 1 | Stop request, takes effect at the frame boundary |
| mode_i | input | 2 | Mode selection, sampled with start |
| expo_i | input | EXP_W | Exposure length in clock cycles |
| clr_mem_i | input | 1 | Pulse both strobes to clear pixel and memory |
| row_done_i | input | 1 | Readout sequencer has finished row `row_idx_i` |
| row_idx_i | input | ROW_W | Index of the row just finished |
| last_row_i | input | ROW_W | Last row of the frame or window |
| row_len_i | input | RLEN_W | Readout row period in cycles |
| open_n_o | output | 1 | Active-low photodiode reset / integration start strobe |
| store_n_o | output | 1 | Active-low charge transfer to pixel memory strobe |
| frame_cap_o | output | 1 | One-cycle flag with each store pulse |

## Verification
A table of start commands runs each mode with exposures that are short, clamped, zero and long. For each one, the bench measures the offset of the open strobe from the start cycle, the distance between the two falling edges and the pulse widths. This separates correct timing from the clamp and from off-by-one errors in the exposure count. Directed overlapped runs drive a regular row-done train. One run checks the end-aligned case, where the store strobe lands on the last row. Another checks the stretched case, where the open strobe fires at the first row. The two runs separate the backward countdown from the immediate fallback. Expose-then-read runs send a row-done for a middle row before the last row, to show that the wait reacts only to the end of the readout. The remaining runs cover clear pulses and a reserved mode, and check that no store pulse overlaps an open pulse.

// File: rtl/gsx_pkg.sv
package gsx_pkg;

   typedef enum logic [1:0] {
      SHM_OVERLAP = 2'b00,
      SHM_SERIAL  = 2'b01,
      SHM_SINGLE  = 2'b10,
      SHM_RSVD    = 2'b11
   } shm_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'b00,
      ST_ARM    = 2'b01,
      ST_EXPOSE = 2'b10,
      ST_WAITRD = 2'b11
   } shx_state_e;

endpackage

// File: rtl/gsx_strobe_gen.sv
module gsx_strobe_gen #(
   parameter int PULSE_W = 3,
   localparam int LEFT_W = $clog2(PULSE_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire_i,
   output logic              strb_n_o,
   output logic              quiet_o,
   output logic [LEFT_W-1:0] left_o
);

   logic [LEFT_W-1:0] left_q;

   generate
      if (PULSE_W < 1) begin : g_bad_width
         $error("gsx_strobe_gen: PULSE_W must be at least 1");
      end
      if (PULSE_W == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) left_q <= '0;
            else        left_q <= fire_i;
         end
      end else begin : g_count
         always_ff @(posedge clk) begin
            if (!rst_n)              left_q <= '0;
            else if (fire_i)         left_q <= LEFT_W'(PULSE_W);
            else if (left_q != '0)   left_q <= left_q - 1'b1;
         end

         p_hold_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (left_q > LEFT_W'(1)) |=> !strb_n_o)
            else $error("p_hold_low_r3: strobe released early");
      end
   endgenerate

   assign strb_n_o = (left_q == '0);
   assign quiet_o  = (left_q <= LEFT_W'(1));
   assign left_o   = left_q;

   p_fire_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fire_i |=> !strb_n_o)
      else $error("p_fire_low_r3: strobe not low after fire");

endmodule

// File: rtl/gsx_expo_timer.sv
module gsx_expo_timer #(
   parameter int EXP_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [EXP_W-1:0] len_i,
   output logic             zero_o
);

   logic [EXP_W-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              left_q <= '0;
      else if (load_i)         left_q <= len_i - 1'b1;
      else if (left_q != '0)   left_q <= left_q - 1'b1;
   end

   assign zero_o = (left_q == '0);

   p_expo_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && left_q != '0) |=> (left_q == $past(left_q) - 1'b1))
      else $error("p_expo_step_r4: exposure count skipped");

   p_expo_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && zero_o) |=> zero_o)
      else $error("p_expo_hold_r4: exposure count wrapped");

endmodule

// File: rtl/gsx_row_timer.sv
module gsx_row_timer #(
   parameter int ROW_W  = 10,
   parameter int RLEN_W = 14,
   localparam int CNT_W = ROW_W + RLEN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              row_done_i,
   input  logic [ROW_W-1:0]  row_idx_i,
   input  logic [ROW_W-1:0]  last_row_i,
   input  logic [RLEN_W-1:0] row_len_i,
   input  logic              drop_i,
   output logic [CNT_W-1:0]  left_o,
   output logic              vld_o
);

   logic [CNT_W-1:0] left_q;
   logic             vld_q;
   logic [ROW_W-1:0] rows_left;
   logic [CNT_W-1:0] span;

   always_comb begin
      rows_left = (row_idx_i < last_row_i) ? (last_row_i - row_idx_i) : '0;
      span      = CNT_W'(rows_left) * CNT_W'(row_len_i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q <= '0;
         vld_q  <= 1'b0;
      end else begin
         if (row_done_i)          left_q <= (span == '0) ? '0 : span - 1'b1;
         else if (left_q != '0)   left_q <= left_q - 1'b1;

         if (drop_i)              vld_q <= 1'b0;
         else if (row_done_i)     vld_q <= 1'b1;
      end
   end

   assign left_o = left_q;
   assign vld_o  = vld_q;

   p_row_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!row_done_i && left_q != '0) |=> (left_q == $past(left_q) - 1'b1))
      else $error("p_row_step_r8: remaining time skipped");

   p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      drop_i |=> !vld_o)
      else $error("p_drop_r8: countdown still valid after store");

endmodule

// File: rtl/gshut_expo_ctrl.sv
module gshut_expo_ctrl
   import gsx_pkg::*;
#(
   parameter int EXP_W   = 24,
   parameter int ROW_W   = 10,
   parameter int RLEN_W  = 14,
   parameter int PULSE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic [1:0]        mode_i,
   input  logic [EXP_W-1:0]  expo_i,
   input  logic              clr_mem_i,
   input  logic              row_done_i,
   input  logic [ROW_W-1:0]  row_idx_i,
   input  logic [ROW_W-1:0]  last_row_i,
   input  logic [RLEN_W-1:0] row_len_i,
   output logic              open_n_o,
   output logic              store_n_o,
   output logic              frame_cap_o
);

   localparam int CNT_W  = ROW_W + RLEN_W;
   localparam int CMP_W  = (EXP_W > CNT_W) ? EXP_W : CNT_W;
   localparam int LEFT_W = $clog2(PULSE_W + 1);

   generate
      if (EXP_W < 2 || EXP_W < LEFT_W) begin : g_bad_exp
         $error("gshut_expo_ctrl: EXP_W too narrow for PULSE_W");
      end
      if (ROW_W < 1 || RLEN_W < 1) begin : g_bad_row
         $error("gshut_expo_ctrl: row widths must be positive");
      end
   endgenerate

   shx_state_e       state_q;
   shm_mode_e        mode_q;
   logic             imm_q, stop_q, end_seen_q, cap_q;
   logic [EXP_W-1:0] eff_expo;
   logic             end_now, start_ok, fire_clr, fire_open, fire_store;
   logic             open_quiet, store_quiet, exp_zero, cnt_vld, near_end;
   logic [CNT_W-1:0] rows_cnt;
   logic [LEFT_W-1:0] open_left, store_left;

   always_comb begin
      eff_expo  = (expo_i < EXP_W'(PULSE_W)) ? EXP_W'(PULSE_W) : expo_i;
      end_now   = row_done_i && (row_idx_i == last_row_i);
      start_ok  = start_i && (mode_i != 2'b11);
      near_end  = cnt_vld && (CMP_W'(rows_cnt) <= CMP_W'(eff_expo));
      fire_clr  = (state_q == ST_IDLE) && clr_mem_i && !start_i;
      fire_open = (state_q == ST_ARM) && !stop_q && open_quiet && store_quiet
                  && (imm_q || near_end);
      fire_store = (state_q == ST_EXPOSE) && exp_zero
                  && (imm_q || end_now || end_seen_q);
   end

   gsx_strobe_gen #(.PULSE_W(PULSE_W)) u_open (
      .clk(clk), .rst_n(rst_n), .fire_i(fire_open | fire_clr),
      .strb_n_o(open_n_o), .quiet_o(open_quiet), .left_o(open_left));

   gsx_strobe_gen #(.PULSE_W(PULSE_W)) u_store (
      .clk(clk), .rst_n(rst_n), .fire_i(fire_store | fire_clr),
      .strb_n_o(store_n_o), .quiet_o(store_quiet), .left_o(store_left));

   gsx_expo_timer #(.EXP_W(EXP_W)) u_expo (
      .clk(clk), .rst_n(rst_n), .load_i(fire_open), .len_i(eff_expo),
      .zero_o(exp_zero));

   gsx_row_timer #(.ROW_W(ROW_W), .RLEN_W(RLEN_W)) u_rows (
      .clk(clk), .rst_n(rst_n), .row_done_i(row_done_i), .row_idx_i(row_idx_i),
      .last_row_i(last_row_i), .row_len_i(row_len_i), .drop_i(fire_store),
      .left_o(rows_cnt), .vld_o(cnt_vld));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         mode_q     <= SHM_OVERLAP;
         imm_q      <= 1'b0;
         stop_q     <= 1'b0;
         end_seen_q <= 1'b0;
         cap_q      <= 1'b0;
      end else begin
         cap_q <= fire_store;
         if (state_q == ST_IDLE)   stop_q <= 1'b0;
         else if (stop_i)          stop_q <= 1'b1;

         if (fire_open)            end_seen_q <= 1'b0;
         else if (state_q == ST_EXPOSE && end_now) end_seen_q <= 1'b1;

         unique case (state_q)
            ST_IDLE: begin
               if (start_ok) begin
                  state_q <= ST_ARM;
                  mode_q  <= shm_mode_e'(mode_i);
                  imm_q   <= 1'b1;
               end
            end
            ST_ARM: begin
               if (stop_q)          state_q <= ST_IDLE;
               else if (fire_open)  state_q <= ST_EXPOSE;
            end
            ST_EXPOSE: begin
               if (fire_store) begin
                  if (mode_q == SHM_SINGLE || stop_q) state_q <= ST_IDLE;
                  else if (mode_q == SHM_SERIAL)      state_q <= ST_WAITRD;
                  else begin
                     state_q <= ST_ARM;
                     imm_q   <= 1'b0;
                  end
               end
            end
            ST_WAITRD: begin
               if (stop_q)        state_q <= ST_IDLE;
               else if (end_now)  state_q <= ST_ARM;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign frame_cap_o = cap_q;

   p_no_overlap_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (!open_n_o && !store_n_o) |-> (open_left == store_left))
      else $error("p_no_overlap_r13: strobes overlap outside a clear");

   p_cap_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_cap_o |-> (!store_n_o && !$past(frame_cap_o)))
      else $error("p_cap_store_r6: frame flag without store pulse");

   p_single_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_store && mode_q == SHM_SINGLE) |=> (state_q == ST_IDLE))
      else $error("p_single_end_r11: single-shot did not idle");

   p_wait_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAITRD && !end_now && !stop_q) |=> (state_q == ST_WAITRD))
      else $error("p_wait_read_r10: left readout wait early");

   p_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && start_i && mode_i == 2'b11) |=> (state_q == ST_IDLE))
      else $error("p_rsvd_r2: reserved mode started a run");

   p_stop_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_store && stop_q) |=> (state_q == ST_IDLE))
      else $error("p_stop_r12: run continued after stop");

endmodule

// File: tb/gshut_expo_ctrl_tb_top.sv
module gshut_expo_ctrl_tb_top;

   localparam int PW = 3;
   localparam int RL = 8;
   localparam int LR = 7;
   localparam int NV = 7;
   // {mode, requested exposure, expected exposure}
   localparam logic [41:0] VEC [NV] = '{
      {2'b01, 24'd10,  16'd10},
      {2'b10, 24'd25,  16'd25},
      {2'b00, 24'd7,   16'd7},
      {2'b01, 24'd1,   16'd3},
      {2'b10, 24'd0,   16'd3},
      {2'b01, 24'd3,   16'd3},
      {2'b00, 24'd300, 16'd300}
   };

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        start_i = 0, stop_i = 0, clr_mem_i = 0, row_done_i = 0;
   logic [1:0]  mode_i = 0;
   logic [23:0] expo_i = 0;
   logic [9:0]  row_idx_i = 0;
   logic [9:0]  last_row_i = 10'(LR);
   logic [13:0] row_len_i = 14'(RL);
   logic        open_n, store_n, cap;

   int cyc = 0, total = 0, bad = 0;
   int open_fall = -1, store_fall = -1, cap_cyc = -1;
   int n_open = 0, n_store = 0, n_cap = 0, ovl = 0;
   int open_run = 0, store_run = 0, open_w = 0, store_w = 0;
   logic open_p = 1'b1, store_p = 1'b1;
   int dk[LR+1];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   gshut_expo_ctrl #(.PULSE_W(PW)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
      .mode_i(mode_i), .expo_i(expo_i), .clr_mem_i(clr_mem_i),
      .row_done_i(row_done_i), .row_idx_i(row_idx_i), .last_row_i(last_row_i),
      .row_len_i(row_len_i), .open_n_o(open_n), .store_n_o(store_n),
      .frame_cap_o(cap));

   always @(negedge clk) begin
      if (!open_n && open_p) begin open_fall = cyc; n_open++; end
      if (!open_n) open_run++;
      else if (!open_p) begin open_w = open_run; open_run = 0; end
      if (!store_n && store_p) begin store_fall = cyc; n_store++; end
      if (!store_n) store_run++;
      else if (!store_p) begin store_w = store_run; store_run = 0; end
      if (!open_n && !store_n && open_fall != store_fall) ovl++;
      if (cap) begin cap_cyc = cyc; n_cap++; end
      open_p = open_n;
      store_p = store_n;
   end

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic go(input logic [1:0] m, output int s);
      @(negedge clk);
      start_i = 1'b1; mode_i = m; s = cyc;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic readout();
      for (int k = 0; k <= LR; k++) begin
         @(negedge clk);
         row_done_i = 1'b1; row_idx_i = 10'(k); dk[k] = cyc;
         @(negedge clk);
         row_done_i = 1'b0;
         tick(RL - 2);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      summary();
      $finish;
   end

   initial begin
      int s, o0, s0, c0, d;
      tick(3);
      // R1: reset state
      chk("R1 open during reset", int'(open_n), 1);
      chk("R1 store during reset", int'(store_n), 1);
      @(negedge clk); rst_n = 1'b1;
      tick(2);
      chk("R1 open after reset", int'(open_n), 1);
      chk("R1 flag after reset", int'(cap), 0);

      // R7: memory clear
      @(negedge clk); clr_mem_i = 1'b1; s = cyc;
      @(negedge clk); clr_mem_i = 1'b0;
      tick(6);
      chk("R7 open fall", open_fall, s + 1);
      chk("R7 store fall", store_fall, s + 1);
      chk("R7 width", store_w, PW);
      chk("R6 no flag on clear", n_cap, 0);

      // R2: reserved mode ignored
      o0 = n_open; s0 = n_store;
      go(2'b11, s);
      tick(20);
      chk("R2 reserved open", n_open - o0, 0);
      chk("R2 reserved store", n_store - s0, 0);

      // table walk: R2 R3 R4 R5 R6 R11 R12
      for (int v = 0; v < NV; v++) begin
         logic [1:0] m;
         int ex;
         m = VEC[v][41:40];
         expo_i = VEC[v][39:16];
         ex = int'(VEC[v][15:0]);
         o0 = n_open; s0 = n_store; c0 = n_cap;
         @(negedge clk);
         start_i = 1'b1; mode_i = m; s = cyc;
         @(negedge clk);
         start_i = 1'b0;
         if (m != 2'b10) stop_i = 1'b1;
         @(negedge clk);
         stop_i = 1'b0;
         tick(ex + 12);
         chk($sformatf("R2 v%0d open offset", v), open_fall - s, 2);
         chk($sformatf("R4 R5 v%0d exposure", v), store_fall - open_fall, ex);
         chk($sformatf("R3 v%0d widths", v), open_w + store_w, 2 * PW);
         chk($sformatf("R6 v%0d flag cycle", v), cap_cyc, store_fall);
         tick(40);
         chk($sformatf("R11 R12 v%0d one open", v), n_open - o0, 1);
         chk($sformatf("R11 R12 v%0d one store", v), n_store - s0, 1);
         chk($sformatf("R6 v%0d one flag", v), n_cap - c0, 1);
      end

      // R8: overlapped, end aligned to last row
      expo_i = 24'd20;
      go(2'b00, s);
      tick(30);
      chk("R8 first frame exposure", store_fall - open_fall, 20);
      readout();
      tick(4);
      chk("R8 store after last row", store_fall, dk[LR] + 1);
      chk("R8 open placed back", open_fall, dk[LR] + 1 - 20);

      // R9: stretch when exposure exceeds remaining readout
      expo_i = 24'd100;
      o0 = n_open;
      readout();
      @(negedge clk); stop_i = 1'b1;
      @(negedge clk); stop_i = 1'b0;
      tick(60);
      chk("R9 open at first row", open_fall, dk[0] + 2);
      chk("R9 stretched exposure", store_fall - open_fall, 100);
      o0 = n_open;
      tick(40);
      chk("R12 idle after stop", n_open - o0, 0);

      // R10: expose-then-read waits for last row only
      expo_i = 24'd10;
      go(2'b01, s);
      tick(16);
      o0 = n_open;
      @(negedge clk); row_done_i = 1'b1; row_idx_i = 10'd3;
      @(negedge clk); row_done_i = 1'b0;
      tick(6);
      chk("R10 middle row ignored", n_open - o0, 0);
      @(negedge clk); row_done_i = 1'b1; row_idx_i = 10'(LR); d = cyc;
      @(negedge clk); row_done_i = 1'b0;
      @(negedge clk); stop_i = 1'b1;
      @(negedge clk); stop_i = 1'b0;
      tick(20);
      chk("R10 next open after last row", open_fall, d + 2);
      chk("R12 frame finishes after stop", store_fall - open_fall, 10);
      o0 = n_open;
      tick(30);
      chk("R12 no strobe after stop", n_open - o0, 0);

      // R13: no overlap seen across the run
      chk("R13 overlap cycles", ovl, 0);

      summary();
      $finish;
   end

endmodule